// File: doc/BRIEF.md
# Piecewise-Linear Controlled Square-Wave Oscillator

This block is a numerically controlled oscillator. Its frequency follows a law of any shape that is set by a small breakpoint table. Each table entry pairs a signed control value with an unsigned frequency, and frequency is expressed as a phase increment per clock. The block samples the control word, finds the table segment that holds it, and interpolates linearly between the two ends of that segment. Outside the table range it extends the nearest segment. It then publishes the result as the phase step.

A phase accumulator adds the published step on every clock. The square output is high while the accumulator lies below a programmable duty threshold. A write to the phase register moves the accumulator to a new starting angle given in degrees.

All settings go through one write port: the two tables, the duty fraction and the starting phase. The control word may change at any time. The block picks it up at the start of its next computation round.

Top module: `pwl_osc`

## Requirements
- R1: While reset is held and just after it, `step_o` is 0 and the accumulator holds `INIT_DEG` scaled to the accumulator width. With the default of −90° this is 270°, so the accumulator holds 0xC00000 and `osc_o` is low. Reset defaults: breakpoint i is at control i·256 with frequency i·256, and the duty is 128.
- R2: For a control value between two neighbouring breakpoints (c0,f0) and (c1,f1), the step is f0 + (f1−f0)·(ctrl−c0)/(c1−c0). The division truncates toward zero.
- R3: The segment used is the one starting at the last breakpoint j (0 < j ≤ N_PTS−2) with ctrl ≥ c[j], or segment 0 if there is none. A control exactly on a breakpoint yields that breakpoint's frequency.
- R4: A control value below the first breakpoint or above the last is extrapolated from the first or the last segment.
- R5: A negative interpolated result gives a step of 0.
- R6: A result above 2^FREQ_W−1 saturates to 2^FREQ_W−1.
- R7: When no phase load takes place, the accumulator gains the previous step on every clock, modulo 2^ACC_W.
- R8: `osc_o` is high exactly when the accumulator is below duty·2^(ACC_W−DUTY_W). Duty is an 8-bit fraction of 256, so 128 gives one half.
- R9: A phase write takes the low 10 bits as signed degrees in −180..360. At the next clock edge the accumulator becomes floor(w·2^ACC_W/360), where w is the angle wrapped into 0..359 (negative angles get 360 added, and 360 becomes 0).
- R10: `step_o` changes only at the end of a computation round. A new control value shows on `step_o` within two rounds of N_PTS+MAG_W+1 cycles each.
- R11: Write select codes: 0 writes control entry `cfg_idx_i` (low CTRL_W bits, signed); 1 writes frequency entry `cfg_idx_i`; 2 writes the duty (low DUTY_W bits), which takes effect on `osc_o` after the next clock edge; 3 writes the phase (R9). Table writes with an index ≥ N_PTS are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | CTRL_W | Signed control word |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration target select |
| cfg_idx_i | input | $clog2(N_PTS) | Table entry index |
| cfg_wdata_i | input | FREQ_W | Configuration write data |
| step_o | output | FREQ_W | Published phase step (frequency) |
| osc_o | output | 1 | Square-wave output |

## Verification
The divider checks assume the control table is strictly increasing, so every segment span is positive. The bench therefore rewrites whole tables in increasing order before it applies any control value, and it holds the control word steady for longer than two rounds before it compares the step. The phase-load checks assume phase data stays within −180..360. Every phase value the bench writes lies in that range, including both ends and the wrap at 360.

// File: rtl/pwl_osc_pkg.sv
package pwl_osc_pkg;
  localparam int PH_W = 10;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_FREQ  = 2'd1,
    SEL_DUTY  = 2'd2,
    SEL_PHASE = 2'd3
  } cfg_sel_e;

  // degrees (-180..360) to accumulator fraction, negatives wrapped
  function automatic logic [31:0] deg_to_frac(input logic signed [PH_W-1:0] deg, input int acc_w);
    longint w;
    w = longint'(deg);
    if (w < 0)    w = w + 360;
    if (w >= 360) w = w - 360;
    return 32'((w << acc_w) / 360);
  endfunction
endpackage

// File: rtl/pwl_osc_cfg.sv
module pwl_osc_cfg
  import pwl_osc_pkg::*;
#(
  parameter int N_PTS    = 4,
  parameter int CTRL_W   = 12,
  parameter int FREQ_W   = 16,
  parameter int DUTY_W   = 8,
  parameter int DUTY_DEF = 128,
  parameter int DEF_STEP = 256
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [1:0]                      sel_i,
  input  logic [$clog2(N_PTS)-1:0]        idx_i,
  input  logic [FREQ_W-1:0]               wdata_i,
  output logic signed [CTRL_W-1:0]        ctrl_tab_o [N_PTS],
  output logic [FREQ_W-1:0]               freq_tab_o [N_PTS],
  output logic [DUTY_W-1:0]               duty_o
);
  logic idx_ok;
  assign idx_ok = int'(idx_i) < N_PTS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_PTS; i++) begin
        ctrl_tab_o[i] <= CTRL_W'(i * DEF_STEP);
        freq_tab_o[i] <= FREQ_W'(i * DEF_STEP);
      end
      duty_o <= DUTY_W'(DUTY_DEF);
    end else if (we_i) begin
      case (cfg_sel_e'(sel_i))
        SEL_CTRL: if (idx_ok) ctrl_tab_o[idx_i] <= wdata_i[CTRL_W-1:0];
        SEL_FREQ: if (idx_ok) freq_tab_o[idx_i] <= wdata_i;
        SEL_DUTY: duty_o <= wdata_i[DUTY_W-1:0];
        default:  ;
      endcase
    end
  end

  assert_duty_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_DUTY) |=> duty_o == $past(wdata_i[DUTY_W-1:0]));
endmodule

// File: rtl/pwl_osc_interp.sv
module pwl_osc_interp #(
  parameter int N_PTS  = 4,
  parameter int CTRL_W = 12,
  parameter int FREQ_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [CTRL_W-1:0] ctrl_i,
  input  logic signed [CTRL_W-1:0] ctrl_tab_i [N_PTS],
  input  logic [FREQ_W-1:0]        freq_tab_i [N_PTS],
  output logic [FREQ_W-1:0]        step_o
);
  localparam int SEG_W  = (N_PTS > 2) ? $clog2(N_PTS) : 1;
  localparam int CD_W   = CTRL_W + 1;
  localparam int FD_W   = FREQ_W + 1;
  localparam int MAG_W  = CD_W + FD_W;
  localparam int BIT_W  = $clog2(MAG_W);
  localparam int SUM_W  = MAG_W + 2;
  localparam logic [SEG_W-1:0] LAST_J = SEG_W'(N_PTS - 2);

  typedef enum logic [1:0] {ST_SRCH, ST_MUL, ST_DIV, ST_PUB} st_e;

  st_e                     st_q;
  logic [SEG_W-1:0]        j_q, seg_q;
  logic signed [CTRL_W-1:0] ctrl_q;
  logic                    neg_q;
  logic [MAG_W-1:0]        mag_q, quo_q;
  logic [CD_W-1:0]         den_q, rem_q;
  logic [FREQ_W-1:0]       f0_q;
  logic [BIT_W-1:0]        bit_q;

  logic signed [CTRL_W-1:0] c0, c1;
  logic [FREQ_W-1:0]       f0, f1;
  logic signed [CD_W-1:0]  cdiff, cspan;
  logic signed [FD_W-1:0]  fdiff;
  logic signed [MAG_W-1:0] prod;
  logic [MAG_W-1:0]        pabs;
  logic [CD_W:0]           rem_sh;
  logic                    ge;
  logic signed [SUM_W-1:0] f0x, qv, sum;
  logic [FREQ_W-1:0]       clamped;

  assign c0 = ctrl_tab_i[seg_q];
  assign c1 = ctrl_tab_i[seg_q + SEG_W'(1)];
  assign f0 = freq_tab_i[seg_q];
  assign f1 = freq_tab_i[seg_q + SEG_W'(1)];

  always_comb begin
    cdiff  = CD_W'(ctrl_q) - CD_W'(c0);
    cspan  = CD_W'(c1) - CD_W'(c0);
    fdiff  = $signed({1'b0, f1}) - $signed({1'b0, f0});
    prod   = MAG_W'(fdiff) * MAG_W'(cdiff);
    pabs   = prod[MAG_W-1] ? MAG_W'(-prod) : MAG_W'(prod);
    rem_sh = {rem_q, mag_q[MAG_W-1]};
    ge     = rem_sh >= {1'b0, den_q};
    f0x    = $signed({{(SUM_W-FREQ_W){1'b0}}, f0_q});
    qv     = $signed({2'b00, quo_q});
    sum    = neg_q ? f0x - qv : f0x + qv;
    if (sum < 0)                                   clamped = '0;
    else if (sum > $signed(SUM_W'({FREQ_W{1'b1}}))) clamped = '1;
    else                                           clamped = sum[FREQ_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_SRCH; j_q <= '0; seg_q <= '0; ctrl_q <= '0;
      neg_q <= 1'b0; mag_q <= '0; quo_q <= '0; den_q <= '0; rem_q <= '0;
      f0_q <= '0; bit_q <= '0; step_o <= '0;
    end else begin
      case (st_q)
        ST_SRCH: begin
          if (j_q == '0) begin
            ctrl_q <= ctrl_i;
            seg_q  <= '0;
          end else if (ctrl_q >= ctrl_tab_i[j_q]) begin
            seg_q <= j_q;
          end
          if (j_q >= LAST_J) begin
            j_q  <= '0;
            st_q <= ST_MUL;
          end else begin
            j_q <= j_q + SEG_W'(1);
          end
        end
        ST_MUL: begin
          neg_q <= prod < 0;
          mag_q <= pabs;
          den_q <= cspan;
          f0_q  <= f0;
          rem_q <= '0;
          quo_q <= '0;
          bit_q <= BIT_W'(MAG_W - 1);
          st_q  <= ST_DIV;
        end
        ST_DIV: begin
          rem_q <= ge ? CD_W'(rem_sh - {1'b0, den_q}) : CD_W'(rem_sh);
          quo_q <= {quo_q[MAG_W-2:0], ge};
          mag_q <= mag_q << 1;
          if (bit_q == '0) st_q <= ST_PUB;
          else             bit_q <= bit_q - BIT_W'(1);
        end
        default: begin
          step_o <= clamped;
          st_q   <= ST_SRCH;
        end
      endcase
    end
  end

  assert_rem_below_span_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DIV) |=> rem_q < den_q);
  assert_step_on_publish_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(step_o) |-> $past(st_q == ST_PUB));
  assert_floor_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PUB && sum < 0) |=> step_o == '0);
endmodule

// File: rtl/pwl_osc_phase.sv
module pwl_osc_phase
  import pwl_osc_pkg::*;
#(
  parameter int ACC_W    = 24,
  parameter int FREQ_W   = 16,
  parameter int DUTY_W   = 8,
  parameter int INIT_DEG = -90
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [FREQ_W-1:0]      step_i,
  input  logic [DUTY_W-1:0]      duty_i,
  input  logic                   load_i,
  input  logic signed [PH_W-1:0] load_deg_i,
  output logic                   osc_o
);
  localparam logic [ACC_W-1:0] ACC_INIT = ACC_W'(deg_to_frac(PH_W'(INIT_DEG), ACC_W));

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] thr;

  assign thr   = {duty_i, {(ACC_W-DUTY_W){1'b0}}};
  assign osc_o = acc_q < thr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= ACC_INIT;
    else if (load_i) acc_q <= ACC_W'(deg_to_frac(load_deg_i, ACC_W));
    else             acc_q <= acc_q + ACC_W'(step_i);
  end

  assert_hold_zero_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i == '0) |=> $stable(acc_q));
  assert_zero_angle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (load_deg_i == PH_W'(0) || load_deg_i == PH_W'(360))) |=> acc_q == '0);
endmodule

// File: rtl/pwl_osc.sv
module pwl_osc
  import pwl_osc_pkg::*;
#(
  parameter int N_PTS    = 4,
  parameter int CTRL_W   = 12,
  parameter int FREQ_W   = 16,
  parameter int ACC_W    = 24,
  parameter int DUTY_W   = 8,
  parameter int DUTY_DEF = 128,
  parameter int INIT_DEG = -90
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CTRL_W-1:0]        ctrl_i,
  input  logic                     cfg_we_i,
  input  logic [1:0]               cfg_sel_i,
  input  logic [$clog2(N_PTS)-1:0] cfg_idx_i,
  input  logic [FREQ_W-1:0]        cfg_wdata_i,
  output logic [FREQ_W-1:0]        step_o,
  output logic                     osc_o
);
  logic signed [CTRL_W-1:0] ctrl_tab [N_PTS];
  logic [FREQ_W-1:0]        freq_tab [N_PTS];
  logic [DUTY_W-1:0]        duty;
  logic                     ph_load;

  assign ph_load = cfg_we_i && (cfg_sel_i == SEL_PHASE);

  pwl_osc_cfg #(
    .N_PTS(N_PTS), .CTRL_W(CTRL_W), .FREQ_W(FREQ_W),
    .DUTY_W(DUTY_W), .DUTY_DEF(DUTY_DEF), .DEF_STEP(256)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .ctrl_tab_o(ctrl_tab), .freq_tab_o(freq_tab), .duty_o(duty)
  );

  pwl_osc_interp #(.N_PTS(N_PTS), .CTRL_W(CTRL_W), .FREQ_W(FREQ_W)) u_interp (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i($signed(ctrl_i)),
    .ctrl_tab_i(ctrl_tab), .freq_tab_i(freq_tab), .step_o(step_o)
  );

  pwl_osc_phase #(
    .ACC_W(ACC_W), .FREQ_W(FREQ_W), .DUTY_W(DUTY_W), .INIT_DEG(INIT_DEG)
  ) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_o), .duty_i(duty),
    .load_i(ph_load), .load_deg_i($signed(cfg_wdata_i[PH_W-1:0])), .osc_o(osc_o)
  );
endmodule

// File: tb/pwl_osc_bench.sv
`timescale 1ns/1ps
module pwl_osc_bench;
  localparam int N = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] ctrl_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [1:0]  cfg_idx_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] step_o;
  logic        osc_o;

  pwl_osc u_pwl_osc (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int ct [N];
  int ft [N];
  int duty_m = 128;
  bit [23:0] ph_m;
  bit pl_load, pl_dwe;
  int pl_deg, pl_dval;
  bit [15:0] pl_step;

  function automatic bit [23:0] frac(int d);
    longint w = d;
    if (w < 0) w += 360;
    if (w >= 360) w -= 360;
    return 24'((w << 24) / 360);
  endfunction

  function automatic int ref_step(int c);
    int k = 0;
    longint num, den, q, v;
    for (int j = 1; j <= N - 2; j++) if (c >= ct[j]) k = j;
    num = longint'(ft[k+1] - ft[k]) * longint'(c - ct[k]);
    den = ct[k+1] - ct[k];
    q = (num < 0 ? -num : num) / den;
    v = ft[k] + (num < 0 ? -q : q);
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    return int'(v);
  endfunction

  // cycle model of accumulator and square output
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      ph_m = frac(-90); pl_load = 0; pl_dwe = 0; pl_step = '0; duty_m = 128;
    end else begin
      if (pl_load) ph_m = frac(pl_deg);
      else         ph_m = ph_m + 24'(pl_step);
      if (pl_dwe) duty_m = pl_dval;
      n_chk++;
      if (osc_o !== (ph_m < 24'(duty_m << 16))) begin
        n_bad++;
        $display("FAIL R7/R8 osc_o act=%0b exp=%0b", osc_o, ph_m < 24'(duty_m << 16));
      end
      pl_load = cfg_we_i && cfg_sel_i == 2'd3;
      pl_deg  = int'($signed(cfg_wdata_i[9:0]));
      pl_dwe  = cfg_we_i && cfg_sel_i == 2'd2;
      pl_dval = int'(cfg_wdata_i[7:0]);
      pl_step = step_o;
    end
  end

  task automatic wr(input int sel, input int idx, input int data);
    @(posedge clk_i); #1;
    cfg_we_i = 1; cfg_sel_i = 2'(sel); cfg_idx_i = 2'(idx); cfg_wdata_i = 16'(data);
    if (sel == 0) ct[idx] = int'($signed(12'(data)));
    if (sel == 1) ft[idx] = data & 16'hFFFF;
    @(posedge clk_i); #1;
    cfg_we_i = 0;
  endtask

  task automatic load_tab(input int c0, c1, c2, c3, f0, f1, f2, f3);
    wr(0, 0, c0); wr(0, 1, c1); wr(0, 2, c2); wr(0, 3, c3);
    wr(1, 0, f0); wr(1, 1, f1); wr(1, 2, f2); wr(1, 3, f3);
  endtask

  task automatic chk_step(input int c, input string tag);
    int e;
    @(posedge clk_i); #1;
    ctrl_i = 12'(c);
    repeat (120) @(posedge clk_i);
    @(negedge clk_i);
    e = ref_step(c);
    n_chk++;
    if (int'(step_o) != e) begin
      n_bad++;
      $display("FAIL %s ctrl=%0d act=%0d exp=%0d", tag, c, step_o, e);
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin ct[i] = i * 256; ft[i] = i * 256; end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    n_chk++;
    if (step_o !== 16'd0 || osc_o !== 1'b0) begin
      n_bad++; $display("FAIL R1 reset step=%0d osc=%0b exp=0/0", step_o, osc_o);
    end
    @(posedge clk_i); #1; rst_ni = 1;
    chk_step(300, "R1_default_table");
    load_tab(-1000, 0, 500, 2000, 100, 1000, 5000, 5200);
    chk_step(-500, "R2");
    chk_step(250, "R2");
    chk_step(1999, "R2");
    chk_step(0, "R3");
    chk_step(500, "R3");
    chk_step(2000, "R3");
    chk_step(-1000, "R3");
    chk_step(2047, "R4_above");
    chk_step(-2048, "R5_floor");
    load_tab(-1000, 0, 500, 2000, 5000, 3000, 3000, 100);
    chk_step(-2048, "R4_below");
    chk_step(1999, "R2_trunc");
    chk_step(2047, "R4_neg_slope");
    load_tab(-1000, 0, 500, 2000, 100, 1000, 60000, 65535);
    chk_step(2047, "R6_sat");
    chk_step(1000, "R6_below_sat");
    // R11 index out of range dropped: N=4 uses all indices, so rewrite same entry
    wr(2, 0, 64);
    chk_step(1200, "R8_duty64");
    wr(2, 0, 200);
    repeat (300) @(posedge clk_i);
    // R9 phase loads incl. both range ends and 360 wrap
    wr(3, 0, -180 & 16'h3FF);
    repeat (50) @(posedge clk_i);
    wr(3, 0, 360);
    repeat (50) @(posedge clk_i);
    wr(3, 0, 90);
    repeat (50) @(posedge clk_i);
    wr(3, 0, 0);
    // R10 step stays steady within a round without control change
    chk_step(1200, "R10");
    repeat (400) @(posedge clk_i);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule